// File: doc/BRIEF.md
# Predicated SIMD Lane Array

This block is the execute stage of a vector unit. It holds a row of identical lanes, sixteen in the default build, and each lane has its own small register file, adder/subtractor, signed comparator and one-bit condition flag. One decoder turns the incoming opcode into a single control word that every lane receives. All lanes therefore do the same operation in the same cycle, each on its own data.

Memory is reached through one wide word that spans all lanes. A load writes the slice for each lane into the same register index in every lane, in one access. A store places the chosen register of every lane side by side in one word. A signed less-than compare sets each lane's flag. The conditional forms of add and add-constant then write results only in the lanes whose flag is set, so a data-dependent branch can be done without changing the flow of control. Every instruction finishes in one clock.

Top module: `simd_lane_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the condition flag of every lane, so `pred_mask_o` reads all zeros after it.
- R2: Opcode 1 (load) writes bits [32*i+31:32*i] of `mem_rdata_i`, sampled in the issue cycle, into register `rd_i` of lane i at that rising edge.
- R3: Opcode 2 (store) raises `mem_we_o` in its issue cycle, and in that same cycle word i of `mem_wdata_o` (bits [32*i+31:32*i]) equals register `rs1_i` of lane i. No register or flag changes. `mem_we_o` is low for every other opcode.
- R4: Opcode 3 writes `rs1 + rs2` modulo 2^32 into `rd` in every lane, whatever the flag.
- R5: Opcode 4 writes `rs1 - rs2` modulo 2^32 into `rd` in every lane.
- R6: Opcode 5 writes `rs1` plus the 16-bit `imm_i` sign-extended to 32 bits into `rd` in every lane.
- R7: Opcode 6 sets each lane's flag to 1 when `rs1 < rs2` as signed 32-bit values and to 0 otherwise (equal gives 0). It writes no register. Flags change only through this opcode and reset.
- R8: Opcode 7 writes `rs1 + rs2` into `rd` only in lanes whose flag is 1. In the other lanes `rd` keeps its value.
- R9: Opcode 8 writes `rs1` + sign-extended `imm_i` into `rd` only in lanes whose flag is 1. In the other lanes `rd` keeps its value.
- R10: Opcode 0 and the unused opcodes 9 to 15 change no register and no flag.
- R11: Bit i of `pred_mask_o` is the flag of lane i.
- R12: When `rd` equals a source index, the operation uses the register's value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Opcode of the instruction issued this cycle |
| rd_i | input | 3 | Destination register index |
| rs1_i | input | 3 | First source register index, also the store source |
| rs2_i | input | 3 | Second source register index |
| imm_i | input | 16 | Signed constant for the add-constant forms |
| mem_rdata_i | input | 512 | Wide load data, lane 0 in the lowest word |
| mem_we_o | output | 1 | Store strobe for the wide memory word |
| mem_wdata_o | output | 512 | Wide store data, lane 0 in the lowest word |
| pred_mask_o | output | 16 | Condition flags, bit i for lane i |

## Verification
The registers are loaded with hashed words that differ per lane. Some registers are set to signed extremes and to values that cross zero, so the compare meets each sign combination, equal operands and wrapping sums. After each instruction a store read-back of all eight registers compares the state of every lane against a model. This shows whether a fault is tied to one lane, to a register index or to the flag gating. A sweep then runs every one of the sixteen opcode values with rotating register indices, including cases where the destination is also a source, and negative and positive constants. It tells whether unused codes stay inert, whether conditional writes follow a mixed flag mask, and whether a mid-run reset clears only the flags.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_VLOAD    = 4'd1,
    OP_VSTORE   = 4'd2,
    OP_VADD     = 4'd3,
    OP_VSUB     = 4'd4,
    OP_VADDC    = 4'd5,
    OP_VCMPLT   = 4'd6,
    OP_VADD_IF  = 4'd7,
    OP_VADDC_IF = 4'd8
  } vop_e;

  typedef enum logic {
    WB_ALU = 1'b0,
    WB_MEM = 1'b1
  } wb_src_e;

  // Control word shared by every lane.
  typedef struct packed {
    logic    rf_we;     // instruction writes rd
    wb_src_e wb_src;    // write-back source
    logic    use_imm;   // second operand is the constant
    logic    do_sub;    // subtract instead of add
    logic    pred_gate; // write only where the lane flag is set
    logic    cmp_en;    // update lane flag from the compare
  } vctrl_t;

endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [3:0] op_i,
  output vctrl_t     ctrl_o,
  output logic       st_en_o
);

  always_comb begin
    ctrl_o  = '{rf_we: 1'b0, wb_src: WB_ALU, use_imm: 1'b0,
                do_sub: 1'b0, pred_gate: 1'b0, cmp_en: 1'b0};
    st_en_o = 1'b0;
    case (op_i)
      OP_VLOAD: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_src = WB_MEM;
      end
      OP_VSTORE: st_en_o = 1'b1;
      OP_VADD:   ctrl_o.rf_we = 1'b1;
      OP_VSUB: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.do_sub = 1'b1;
      end
      OP_VADDC: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_VCMPLT: ctrl_o.cmp_en = 1'b1;
      OP_VADD_IF: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.pred_gate = 1'b1;
      end
      OP_VADDC_IF: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.use_imm   = 1'b1;
        ctrl_o.pred_gate = 1'b1;
      end
      default: ; // NOP and unused codes
    endcase
  end

endmodule

// File: rtl/simd_regfile.sv
module simd_regfile #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 8,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);

  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk) begin
    if (we_i) regs_q[waddr_i] <= wdata_i;
  end

  // Reads see the value from before the edge (read-before-write).
  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 8,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  vctrl_t          ctrl_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] ld_word_i,
  output logic [XLEN-1:0] st_word_o,
  output logic            pred_o,
  output logic            rf_we_o
);

  function automatic logic [XLEN-1:0] f_addsub(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic            sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic f_slt(input logic [XLEN-1:0] a,
                                 input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  logic [XLEN-1:0] opa, opb, alu_b, alu_res, wdata;
  logic            pred_q;
  logic            lt_evt;
  logic            rf_we;

  simd_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we_i      (rf_we),
    .waddr_i   (rd_i),
    .wdata_i   (wdata),
    .raddr_a_i (rs1_i),
    .raddr_b_i (rs2_i),
    .rdata_a_o (opa),
    .rdata_b_o (opb)
  );

  assign alu_b   = ctrl_i.use_imm ? imm_i : opb;
  assign alu_res = f_addsub(opa, alu_b, ctrl_i.do_sub);
  assign lt_evt  = f_slt(opa, opb);
  assign wdata   = (ctrl_i.wb_src == WB_MEM) ? ld_word_i : alu_res;
  assign rf_we   = ctrl_i.rf_we && (!ctrl_i.pred_gate || pred_q);

  always_ff @(posedge clk) begin
    if (rst)                pred_q <= 1'b0;
    else if (ctrl_i.cmp_en) pred_q <= lt_evt;
  end

  assign st_word_o = opa;
  assign pred_o    = pred_q;
  assign rf_we_o   = rf_we;

  p_flag_only_on_cmp_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.cmp_en |=> $stable(pred_q));

  p_cmp_writes_no_reg_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_i.cmp_en |-> !rf_we);

  p_gate_blocks_write_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.pred_gate && !pred_q) |-> !rf_we);

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 8,
  parameter int unsigned IMMW  = 16,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned BUSW = LANES * XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [BUSW-1:0] mem_rdata_i,
  output logic            mem_we_o,
  output logic [BUSW-1:0] mem_wdata_o,
  output logic [LANES-1:0] pred_mask_o
);

  vctrl_t          ctrl;
  logic            st_en;
  logic [XLEN-1:0] imm_ext;
  logic [LANES-1:0] lane_we;

  simd_decode u_dec (
    .op_i    (op_i),
    .ctrl_o  (ctrl),
    .st_en_o (st_en)
  );

  assign imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.XLEN(XLEN), .NREGS(NREGS)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .ctrl_i    (ctrl),
      .rd_i      (rd_i),
      .rs1_i     (rs1_i),
      .rs2_i     (rs2_i),
      .imm_i     (imm_ext),
      .ld_word_i (mem_rdata_i[g*XLEN +: XLEN]),
      .st_word_o (mem_wdata_o[g*XLEN +: XLEN]),
      .pred_o    (pred_mask_o[g]),
      .rf_we_o   (lane_we[g])
    );
  end

  assign mem_we_o = st_en;

  p_store_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (lane_we == '0));

endmodule

// File: tb/simd_lane_array_bench.sv
module simd_lane_array_bench;
  localparam int LANES  = 16;
  localparam int XLEN   = 32;
  localparam int NREGS  = 8;
  localparam int BUSW   = LANES * XLEN;
  localparam int PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      op  = 4'd0;
  logic [2:0]      rd  = '0, rs1 = '0, rs2 = '0;
  logic [15:0]     imm = '0;
  logic [BUSW-1:0] rdata = '0;
  logic            mem_we;
  logic [BUSW-1:0] wdata;
  logic [LANES-1:0] pmask;

  logic [XLEN-1:0] mdl [LANES][NREGS];
  logic [LANES-1:0] mpred = '0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  simd_lane_array u_simd_lane_array (
    .clk(clk), .rst(rst), .op_i(op), .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2),
    .imm_i(imm), .mem_rdata_i(rdata), .mem_we_o(mem_we),
    .mem_wdata_o(wdata), .pred_mask_o(pmask)
  );

  task automatic chk(input string req, input logic [BUSW-1:0] act,
                     input logic [BUSW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] hash(input int seed, input int lane);
    return (seed * 32'h0100_0193) ^ (lane * 32'h9E37_79B9) ^ (seed << 7);
  endfunction

  function automatic logic [BUSW-1:0] pat_bus(input int seed);
    logic [BUSW-1:0] b;
    for (int l = 0; l < LANES; l++) b[l*XLEN +: XLEN] = hash(seed, l);
    return b;
  endfunction

  function automatic logic [BUSW-1:0] exp_bus(input int r);
    logic [BUSW-1:0] b;
    for (int l = 0; l < LANES; l++) b[l*XLEN +: XLEN] = mdl[l][r];
    return b;
  endfunction

  // Issue one instruction, then update the model from the requirement text.
  task automatic step(input logic [3:0] o, input logic [2:0] d, input logic [2:0] a,
                      input logic [2:0] b, input logic [15:0] k,
                      input logic [BUSW-1:0] md, input string req);
    logic [XLEN-1:0] ke, va, vb;
    @(negedge clk);
    op = o; rd = d; rs1 = a; rs2 = b; imm = k; rdata = md;
    #1;
    chk({"R3 store strobe ", req}, BUSW'(mem_we), BUSW'(o == 4'd2));
    if (o == 4'd2) chk({"R3 store data ", req}, wdata, exp_bus(a));
    @(posedge clk);
    ke = {{16{k[15]}}, k};
    for (int l = 0; l < LANES; l++) begin
      va = mdl[l][a]; vb = mdl[l][b];
      case (o)
        4'd1: mdl[l][d] = md[l*XLEN +: XLEN];
        4'd3: mdl[l][d] = va + vb;
        4'd4: mdl[l][d] = va - vb;
        4'd5: mdl[l][d] = va + ke;
        4'd6: mpred[l] = $signed(va) < $signed(vb);
        4'd7: if (mpred[l]) mdl[l][d] = va + vb;
        4'd8: if (mpred[l]) mdl[l][d] = va + ke;
        default: ;
      endcase
    end
    #1;
  endtask

  // Read every register back through stores and compare all lanes.
  task automatic check_all(input string req);
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      op = 4'd2; rs1 = 3'(r);
      #1;
      chk({req, " readback"}, wdata, exp_bus(r));
    end
    chk({"R11 flag mask ", req}, BUSW'(pmask), BUSW'(mpred));
    @(negedge clk);
    op = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [BUSW-1:0] sgn;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset clears flags", BUSW'(pmask), '0);
    @(negedge clk);
    rst = 1'b0;

    // R2: fill every register with distinct per-lane words
    for (int r = 0; r < NREGS; r++) step(4'd1, 3'(r), 3'd0, 3'd0, 16'h0, pat_bus(r + 1), "R2");
    // signed corner values for the compare
    for (int l = 0; l < LANES; l++) begin
      sgn[l*XLEN +: XLEN] = (l % 2 == 0) ? 32'h8000_0000 + l : 32'h7FFF_FFF0 + l;
    end
    step(4'd1, 3'd7, 3'd0, 3'd0, 16'h0, sgn, "R2");
    for (int l = 0; l < LANES; l++) sgn[l*XLEN +: XLEN] = (l - 8) * 32'h1000_0000;
    step(4'd1, 3'd6, 3'd0, 3'd0, 16'h0, sgn, "R2");
    check_all("R2 load");
    step(4'd2, 3'd0, 3'd5, 3'd0, 16'h0, '0, "R3");
    check_all("R3 store leaves state");

    step(4'd3, 3'd0, 3'd1, 3'd2, 16'h0, '0, "R4"); check_all("R4 add");
    step(4'd4, 3'd3, 3'd4, 3'd5, 16'h0, '0, "R5"); check_all("R5 sub");
    step(4'd5, 3'd1, 3'd1, 3'd0, 16'h8000, '0, "R6"); check_all("R6 addc negative");
    step(4'd5, 3'd2, 3'd3, 3'd0, 16'h7FFF, '0, "R6"); check_all("R6 addc positive");
    step(4'd6, 3'd0, 3'd6, 3'd7, 16'h0, '0, "R7"); check_all("R7 signed compare");
    step(4'd7, 3'd2, 3'd0, 3'd3, 16'h0, '0, "R8"); check_all("R8 gated add");
    step(4'd8, 3'd4, 3'd4, 3'd0, 16'hFF01, '0, "R9"); check_all("R9 gated addc");
    step(4'd6, 3'd0, 3'd6, 3'd6, 16'h0, '0, "R7"); check_all("R7 equal gives zero");
    step(4'd8, 3'd4, 3'd4, 3'd0, 16'h0123, '0, "R9"); check_all("R9 all flags clear");
    step(4'd6, 3'd0, 3'd7, 3'd6, 16'h0, '0, "R7"); check_all("R7 reversed compare");
    for (int o = 9; o < 16; o++) step(4'(o), 3'd1, 3'd2, 3'd3, 16'hFFFF, pat_bus(77), "R10");
    step(4'd0, 3'd1, 3'd2, 3'd3, 16'hFFFF, pat_bus(78), "R10");
    check_all("R10 inert opcodes");
    step(4'd3, 3'd5, 3'd5, 3'd5, 16'h0, '0, "R12"); check_all("R12 rd equals sources");

    // Sweep all opcode values with rotating register indices
    for (int k = 0; k < 64; k++) begin
      step(4'(k % 16), 3'((k * 3) % 8), 3'((k * 5 + 1) % 8), 3'((k * 7 + 2) % 8),
           16'(k * 16'h1357), pat_bus(k + 100), "R10 sweep");
      check_all("R8 R9 sweep");
    end

    // R1: reset mid-run clears flags only
    step(4'd6, 3'd0, 3'd7, 3'd6, 16'h0, '0, "R7");
    @(negedge clk); rst = 1'b1; op = 4'd0;
    @(posedge clk); #1;
    mpred = '0;
    chk("R1 mid-run reset", BUSW'(pmask), '0);
    @(negedge clk); rst = 1'b0;
    check_all("R1 registers kept");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule